// File: doc/BRIEF.md
# Bit-Pattern Condition Flag and Branch Unit

This block adds two condition flags to an integer pipeline. Unlike the usual arithmetic flags, these two describe the bit pattern of a 32-bit value. The sparse flag reports that the value's significant span has more 0 bits than 1 bits. The span starts at the highest set bit and ends at bit 0. The quad flag reports that the value has exactly four set bits.

The flags change only when an add or a move retires. An add classifies its sum, and a move classifies the value being moved. Every other instruction class leaves both flags as they were.

Two conditional jumps read the committed flags together with the ordinary overflow flag, which the block receives as an input. The block reports whether the selected jump is taken. Fetch, decode, target computation and the standard flags stay outside. A retiring instruction changes the flags at the clock edge that ends its cycle. A jump evaluated in that same cycle still sees the flags left by earlier instructions.

Top module: `patflag_branch_unit`

## Requirements
- R1: The sparse class holds for a value when the span from its highest set bit down to bit 0 contains more 0 bits than 1 bits. Examples: 0x12 and 0x4 are sparse. 0x2 is not sparse, because its counts are equal. An all-zero value is never sparse.
- R2: The quad class holds when the value has exactly QUAD_COUNT set bits (default 4). Examples: 0x36 and 0xF0 are quad. 0x1F is not quad.
- R3: When `retire_valid` is 1 and `op_class` is 2'b01 (add), both flags take the classes of `value` at the next rising clock edge.
- R4: When `retire_valid` is 1 and `op_class` is 2'b10 (move), both flags take the classes of `value` at the next rising clock edge.
- R5: Both flags keep their value across the clock edge in two cases: `op_class` is 2'b00 (other) or 2'b11 (reserved), or `retire_valid` is 0.
- R6: With `br_valid`=1 and `br_sel`=0 (sparse jump), `br_taken` is 1 exactly when the sparse flag is 1 and `ovf_in` is 0.
- R7: With `br_valid`=1 and `br_sel`=1 (quad jump), `br_taken` is 1 exactly when the quad flag is 1 and `ovf_in` is 0. With `br_valid`=0, `br_taken` is 0.
- R8: A jump is evaluated against the committed flags. A value retiring in the same cycle does not change `br_taken` until after the clock edge.
- R9: The active-low asynchronous reset clears both flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| retire_valid | input | 1 | An instruction retires this cycle |
| op_class | input | 2 | 00 other, 01 add, 10 move, 11 reserved |
| value | input | DATA_W | Add sum or move source value |
| ovf_in | input | 1 | Standard overflow flag |
| br_valid | input | 1 | A flag-based jump is evaluated this cycle |
| br_sel | input | 1 | 0 sparse jump, 1 quad jump |
| br_taken | output | 1 | The selected jump is taken |
| sparse_flag | output | 1 | Committed sparse flag |
| quad_flag | output | 1 | Committed quad flag |

## Verification
The bench builds the block with its default parameters: a 32-bit value and a quad count of 4.

This width brings the following patterns within reach:
- a single set bit at position 31, which gives the longest span;
- a negative value with thirty set bits;
- span lengths where the zero and one counts tie exactly (0x2, 0xF0), which separate a strict comparison from an inclusive one.

Every vector is checked for both jump kinds, with overflow set and with overflow clear.

// File: rtl/patflag_pkg.sv
package patflag_pkg;

  typedef enum logic [1:0] {
    OPC_OTHER = 2'b00,
    OPC_ADD   = 2'b01,
    OPC_MOVE  = 2'b10,
    OPC_RSVD  = 2'b11
  } op_class_e;

  typedef enum logic {
    BR_SPARSE = 1'b0,
    BR_QUAD   = 1'b1
  } br_kind_e;

endpackage

// File: rtl/patflag_classifier.sv
module patflag_classifier #(
  parameter int DATA_W     = 32,
  parameter int QUAD_COUNT = 4
) (
  input  logic [DATA_W-1:0] value,
  output logic              is_sparse,
  output logic              is_quad
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  // Span length: index of the highest set bit plus one, zero for an all-zero value.
  function automatic logic [CNT_W-1:0] span_of(input logic [DATA_W-1:0] v);
    logic [CNT_W-1:0] s;
    s = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (v[i]) s = CNT_W'(i + 1);
    end
    return s;
  endfunction

  function automatic logic [CNT_W-1:0] ones_of(input logic [DATA_W-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < DATA_W; i++) begin
      c = c + CNT_W'(v[i]);
    end
    return c;
  endfunction

  logic [CNT_W-1:0] span_len;
  logic [CNT_W-1:0] ones_cnt;
  logic [CNT_W:0]   twice_ones;

  always_comb begin
    span_len   = span_of(value);
    ones_cnt   = ones_of(value);
    twice_ones = {ones_cnt, 1'b0};
    // zeros in span exceed ones  <=>  span > 2 * ones (zero value gives 0 > 0)
    is_sparse  = {1'b0, span_len} > twice_ones;
    is_quad    = (ones_cnt == CNT_W'(QUAD_COUNT));
  end

endmodule

// File: rtl/patflag_regs.sv
module patflag_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_en,
  input  logic nxt_sparse,
  input  logic nxt_quad,
  output logic sparse_q,
  output logic quad_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sparse_q <= 1'b0;
      quad_q   <= 1'b0;
    end else if (upd_en) begin
      sparse_q <= nxt_sparse;
      quad_q   <= nxt_quad;
    end
  end
endmodule

// File: rtl/patflag_branch_eval.sv
module patflag_branch_eval
  import patflag_pkg::*;
(
  input  logic br_valid,
  input  logic br_sel,
  input  logic ovf_in,
  input  logic sparse_q,
  input  logic quad_q,
  output logic br_taken
);
  logic cond_flag;

  always_comb begin
    cond_flag = (br_sel == BR_QUAD) ? quad_q : sparse_q;
    br_taken  = br_valid && cond_flag && !ovf_in;
  end
endmodule

// File: rtl/patflag_branch_unit.sv
module patflag_branch_unit
  import patflag_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int QUAD_COUNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retire_valid,
  input  logic [1:0]        op_class,
  input  logic [DATA_W-1:0] value,
  input  logic              ovf_in,
  input  logic              br_valid,
  input  logic              br_sel,
  output logic              br_taken,
  output logic              sparse_flag,
  output logic              quad_flag
);
  logic cls_sparse;
  logic cls_quad;
  logic flag_upd;

  assign flag_upd = retire_valid &&
                    ((op_class == OPC_ADD) || (op_class == OPC_MOVE));

  patflag_classifier #(
    .DATA_W    (DATA_W),
    .QUAD_COUNT(QUAD_COUNT)
  ) u_cls (
    .value    (value),
    .is_sparse(cls_sparse),
    .is_quad  (cls_quad)
  );

  patflag_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (flag_upd),
    .nxt_sparse(cls_sparse),
    .nxt_quad  (cls_quad),
    .sparse_q  (sparse_flag),
    .quad_q    (quad_flag)
  );

  patflag_branch_eval u_br (
    .br_valid(br_valid),
    .br_sel  (br_sel),
    .ovf_in  (ovf_in),
    .sparse_q(sparse_flag),
    .quad_q  (quad_flag),
    .br_taken(br_taken)
  );

endmodule

// File: rtl/patflag_checks.sv
module patflag_checks #(
  parameter int DATA_W     = 32,
  parameter int QUAD_COUNT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] value,
  input logic              ovf_in,
  input logic              br_valid,
  input logic              br_sel,
  input logic              br_taken,
  input logic              sparse_flag,
  input logic              quad_flag,
  input logic              cls_sparse,
  input logic              cls_quad,
  input logic              flag_upd
);
  // R1
  sparse_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cls_sparse |-> (value != '0));

  // R2
  quad_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cls_quad |-> ($countones(value) == QUAD_COUNT));

  // R3 R4
  flag_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_upd |=> (sparse_flag == $past(cls_sparse)) && (quad_flag == $past(cls_quad)));

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_upd |=> $stable(sparse_flag) && $stable(quad_flag));

  // R6 R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (!ovf_in && br_valid));

  // R7
  quad_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_sel && !ovf_in && quad_flag) |-> br_taken);
endmodule

bind patflag_branch_unit patflag_checks #(
  .DATA_W    (DATA_W),
  .QUAD_COUNT(QUAD_COUNT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .value      (value),
  .ovf_in     (ovf_in),
  .br_valid   (br_valid),
  .br_sel     (br_sel),
  .br_taken   (br_taken),
  .sparse_flag(sparse_flag),
  .quad_flag  (quad_flag),
  .cls_sparse (cls_sparse),
  .cls_quad   (cls_quad),
  .flag_upd   (flag_upd)
);

// File: tb/patflag_branch_unit_test.sv
`timescale 1ns/1ps
module patflag_branch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire_valid = 1'b0;
  logic [1:0]  op_class = 2'b00;
  logic [31:0] value = '0;
  logic        ovf_in = 1'b0;
  logic        br_valid = 1'b0;
  logic        br_sel = 1'b0;
  logic        br_taken, sparse_flag, quad_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  patflag_branch_unit uut (
    .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid), .op_class(op_class),
    .value(value), .ovf_in(ovf_in), .br_valid(br_valid), .br_sel(br_sel),
    .br_taken(br_taken), .sparse_flag(sparse_flag), .quad_flag(quad_flag)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] val;
    logic        ovf;
    logic        es;
    logic        eq;
  } vec_t;

  // op: 0 other, 1 add, 2 move, 3 reserved; es/eq are committed flags after the edge
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 32'h0000_0012, 1'b0, 1'b1, 1'b0},  // R3 R1: 10010
    '{2'd2, 32'hFFFF_FFEE, 1'b0, 1'b0, 1'b0},  // R4: thirty ones
    '{2'd1, 32'h0000_0036, 1'b0, 1'b0, 1'b1},  // R3 R2: four ones
    '{2'd0, 32'h0000_0024, 1'b0, 1'b0, 1'b1},  // R5: other holds
    '{2'd2, 32'h0000_0024, 1'b0, 1'b1, 1'b0},  // R4
    '{2'd3, 32'h0000_000F, 1'b0, 1'b1, 1'b0},  // R5: reserved holds
    '{2'd1, 32'h0000_000F, 1'b1, 1'b0, 1'b1},  // R7 with overflow
    '{2'd2, 32'h0000_0000, 1'b0, 1'b0, 1'b0},  // R1: zero not sparse
    '{2'd1, 32'h8000_0000, 1'b0, 1'b1, 1'b0},  // R1: top bit
    '{2'd2, 32'h0000_0002, 1'b0, 1'b0, 1'b0},  // R1: tie
    '{2'd2, 32'h0000_0004, 1'b0, 1'b1, 1'b0},  // R1
    '{2'd1, 32'h0000_00F0, 1'b0, 1'b0, 1'b1},  // R1 tie, R2
    '{2'd2, 32'h0000_01E0, 1'b1, 1'b1, 1'b1},  // R6 R7 overflow blocks
    '{2'd2, 32'h0000_01E0, 1'b0, 1'b1, 1'b1},  // R6 R7
    '{2'd1, 32'h0000_0001, 1'b0, 1'b0, 1'b0},  // R1 single bit
    '{2'd2, 32'h000F_0000, 1'b0, 1'b1, 1'b1}   // R1 R2
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic retire(input logic [1:0] op, input logic [31:0] v);
    retire_valid = 1'b1; op_class = op; value = v;
    @(posedge clk);
    #2;
    retire_valid = 1'b0; op_class = 2'b00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    #12;
    // R9: reset state
    check("R9 sparse after reset", sparse_flag, 1'b0);
    check("R9 quad after reset", quad_flag, 1'b0);
    br_valid = 1'b1; br_sel = 1'b0; #1;
    check("R6 no take after reset", br_taken, 1'b0);
    br_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      retire(VEC[i].op, VEC[i].val);
      ovf_in = VEC[i].ovf;
      #1;
      check("R3/R4/R5 sparse flag", sparse_flag, VEC[i].es);
      check("R3/R4/R5 quad flag", quad_flag, VEC[i].eq);
      br_valid = 1'b1; br_sel = 1'b0; #1;
      check("R6 sparse jump", br_taken, VEC[i].es & ~VEC[i].ovf);
      br_sel = 1'b1; #1;
      check("R7 quad jump", br_taken, VEC[i].eq & ~VEC[i].ovf);
      br_valid = 1'b0; #1;
      check("R7 no request", br_taken, 1'b0);
      ovf_in = 1'b0;
      @(negedge clk);
    end

    // R8: flags are (1,1); a zero retiring now must not affect the current jump
    retire_valid = 1'b1; op_class = 2'b01; value = 32'h0;
    br_valid = 1'b1; br_sel = 1'b0; #1;
    check("R8 sparse jump uses committed flag", br_taken, 1'b1);
    br_sel = 1'b1; #1;
    check("R8 quad jump uses committed flag", br_taken, 1'b1);
    @(posedge clk); #2;
    retire_valid = 1'b0;
    check("R8 after edge", br_taken, 1'b0);
    br_valid = 1'b0;
    @(negedge clk);

    // R5: add value with retire_valid low must not load
    retire_valid = 1'b0; op_class = 2'b01; value = 32'h0000_0036;
    @(posedge clk); #2;
    check("R5 sparse held when not retiring", sparse_flag, 1'b0);
    check("R5 quad held when not retiring", quad_flag, 1'b0);
    op_class = 2'b00;
    @(negedge clk);

    // R9: asynchronous reset mid-cycle
    retire(2'd2, 32'h0000_01E0);
    check("R4 set before reset", quad_flag, 1'b1);
    @(negedge clk); #2;
    rst_n = 1'b0; #1;
    check("R9 async clear sparse", sparse_flag, 1'b0);
    check("R9 async clear quad", quad_flag, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule